// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

A 32-bit processor core that fetches, decodes, executes, accesses memory and writes back one instruction per clock. It executes six instructions: register add and register subtract (both wrapping, with no overflow signalling), OR with a zero-padded 16-bit immediate, word load, word store, and branch when two registers are equal. Every other encoding behaves as a no-op that only moves the program counter forward.

Instruction memory and data memory sit outside the core. The core presents a byte address for the next instruction and reads the instruction word back combinationally. For data it presents an address, write data and a write strobe. Loads read data combinationally in the same cycle, and a store is committed by the memory on the same rising edge that updates the program counter and the register file. The core holds 32 general registers, and register 0 is hard-wired to zero.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and `dmem_we` is 0 (the reset instruction at address 0 is not a store). The first instruction fetched after release is the one at address 0.
- R2: An R-format word (op = instr[31:26] = 0x00, rs = [25:21], rt = [20:16], rd = [15:11], funct = [5:0]) with funct 0x21 writes rs + rt, modulo 2^32, into rd.
- R3: R-format funct 0x23 writes rs - rt, modulo 2^32, into rd.
- R4: op 0x0D writes rs OR {16'h0, instr[15:0]} into rt. The immediate is zero-padded, never sign-extended.
- R5: op 0x23 drives `dmem_addr` = rs + sign-extended instr[15:0], with `dmem_we` low, and writes `dmem_rdata` into rt.
- R6: op 0x2B drives `dmem_we` high, `dmem_addr` = rs + sign-extended instr[15:0], and `dmem_wdata` = rt. No register changes.
- R7: op 0x04 with rs equal to rt makes the next `imem_addr` equal to PC + 4 + (sign-extended instr[15:0] << 2). Negative offsets are included.
- R8: op 0x04 with rs not equal to rt makes the next `imem_addr` equal to PC + 4.
- R9: Register 0 always reads as 0, and a write aimed at it has no effect.
- R10: Any other op value, or op 0x00 with a funct other than 0x21 and 0x23, writes neither a register nor memory and advances the PC by 4.
- R11: Outside a taken branch, `imem_addr` advances by exactly 4 on every clock edge after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
The core is observed only through its two memory interfaces. A wrong PC shows up on `imem_addr` at the next edge. A wrong register value stays hidden until a later store, branch or address computation reads that register, so the program writes every computed register to memory soon after producing it. Branch decisions and decode faults change the fetch sequence or the store strobe within one cycle. Register-0 and no-op faults are made visible by later stores of the registers they could have corrupted.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam logic [5:0] OPC_RFMT = 6'h00;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_LOAD = 6'h23;
  localparam logic [5:0] OPC_STOR = 6'h2B;
  localparam logic [5:0] OPC_BREQ = 6'h04;
  localparam logic [5:0] FN_ADD   = 6'h21;
  localparam logic [5:0] FN_SUB   = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;     // destination from rd field, else rt
    logic    b_imm;      // ALU operand B from extended immediate
    logic    ext_sign;   // sign-extend immediate, else zero-pad
    logic    wb_mem;     // write-back from data memory
    logic    mem_we;     // store
    logic    reg_we;     // register write
    logic    is_branch;  // equality branch
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  always_comb begin
    ctl = '0;
    unique case (op)
      OPC_RFMT: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctl.dst_rd = 1'b1;
          ctl.reg_we = 1'b1;
          ctl.alu_op = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OPC_ORI: begin
        ctl.b_imm  = 1'b1;
        ctl.reg_we = 1'b1;
        ctl.alu_op = ALU_OR;
      end
      OPC_LOAD: begin
        ctl.b_imm    = 1'b1;
        ctl.ext_sign = 1'b1;
        ctl.wb_mem   = 1'b1;
        ctl.reg_we   = 1'b1;
        ctl.alu_op   = ALU_ADD;
      end
      OPC_STOR: begin
        ctl.b_imm    = 1'b1;
        ctl.ext_sign = 1'b1;
        ctl.mem_we   = 1'b1;
        ctl.alu_op   = ALU_ADD;
      end
      OPC_BREQ: begin
        ctl.ext_sign  = 1'b1;
        ctl.is_branch = 1'b1;
        ctl.alu_op    = ALU_SUB;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic [AW-1:0] rw,
  input  logic          we,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);

  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      logic [W-1:0] q;
      logic         en;
      assign en = we && (rw == AW'(g));
      always_ff @(posedge clk) begin
        if (en) q <= wd;
      end
      assign regs[g] = q;
    end
  end

  assign qa = regs[ra];
  assign qb = regs[rb];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_nextpc.sv
module sc_nextpc #(
  parameter int W = 32
) (
  input  logic [W-1:0] pc,
  input  logic [W-1:0] imm_ext,
  input  logic         take,
  output logic [W-1:0] pc_nxt
);

  logic [W-1:0] seq_pc;
  logic [W-1:0] tgt_pc;

  assign seq_pc = pc + W'(4);
  assign tgt_pc = seq_pc + {imm_ext[W-3:0], 2'b00};
  assign pc_nxt = take ? tgt_pc : seq_pc;

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] imem_addr,
  input  logic [W-1:0] imem_rdata,
  output logic [W-1:0] dmem_addr,
  output logic [W-1:0] dmem_wdata,
  output logic         dmem_we,
  input  logic [W-1:0] dmem_rdata
);

  localparam int AW = $clog2(NREG);
  localparam int IW = 16;

  logic [W-1:0]  pc_q;
  logic [W-1:0]  pc_nxt;
  ctrl_t         ctl;
  logic [5:0]    f_op;
  logic [5:0]    f_fn;
  logic [AW-1:0] f_rs;
  logic [AW-1:0] f_rt;
  logic [AW-1:0] f_rd;
  logic [IW-1:0] f_imm;
  logic          unused_shamt;
  logic [W-1:0]  imm_ext;
  logic [W-1:0]  rf_qa;
  logic [W-1:0]  rf_qb;
  logic [W-1:0]  alu_b;
  logic [W-1:0]  alu_y;
  logic          alu_zero;
  logic [AW-1:0] wr_idx;
  logic [W-1:0]  wr_data;
  logic          rf_we;
  logic          br_take;

  assign f_op  = imem_rdata[31:26];
  assign f_rs  = imem_rdata[21 +: AW];
  assign f_rt  = imem_rdata[16 +: AW];
  assign f_rd  = imem_rdata[11 +: AW];
  assign f_fn  = imem_rdata[5:0];
  assign f_imm = imem_rdata[IW-1:0];
  assign unused_shamt = ^imem_rdata[10:6];

  sc_decode u_dec (
    .op    (f_op),
    .funct (f_fn),
    .ctl   (ctl)
  );

  assign imm_ext = ctl.ext_sign ? {{(W-IW){f_imm[IW-1]}}, f_imm}
                                : {{(W-IW){1'b0}}, f_imm};

  assign wr_idx  = ctl.dst_rd ? f_rd : f_rt;
  assign wr_data = ctl.wb_mem ? dmem_rdata : alu_y;
  assign rf_we   = ctl.reg_we;

  sc_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk (clk),
    .ra  (f_rs),
    .rb  (f_rt),
    .rw  (wr_idx),
    .we  (rf_we),
    .wd  (wr_data),
    .qa  (rf_qa),
    .qb  (rf_qb)
  );

  assign alu_b = ctl.b_imm ? imm_ext : rf_qb;

  sc_alu #(.W(W)) u_alu (
    .a    (rf_qa),
    .b    (alu_b),
    .op   (ctl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign br_take = ctl.is_branch & alu_zero;

  sc_nextpc #(.W(W)) u_npc (
    .pc      (pc_q),
    .imm_ext (imm_ext),
    .take    (br_take),
    .pc_nxt  (pc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_nxt;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rf_qb;
  assign dmem_we    = ctl.mem_we;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] pc,
  input logic [5:0]   op,
  input logic [5:0]   funct,
  input logic [4:0]   rs_idx,
  input logic [15:0]  imm,
  input logic [W-1:0] rs_q,
  input logic [W-1:0] alu_b,
  input logic         rf_we,
  input logic         mem_we,
  input logic         br_take
);

  logic [W-1:0] boff;
  logic         legal;

  assign boff  = {{(W-18){imm[15]}}, imm, 2'b00};
  assign legal = (op == 6'h00 && (funct == 6'h21 || funct == 6'h23)) ||
                 op == 6'h0D || op == 6'h23 || op == 6'h2B || op == 6'h04;

  assert_pc_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> pc == '0);

  assert_pc_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(br_take)) |-> pc == $past(pc) + W'(4));

  assert_branch_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(br_take)) |-> pc == $past(pc) + W'(4) + $past(boff));

  assert_reg0_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_idx == 5'd0) |-> rs_q == '0);

  assert_store_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (op == 6'h2B && !rf_we));

  assert_nop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |-> (!rf_we && !mem_we && !br_take));

  assert_ori_zero_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'h0D) |-> alu_b[W-1:16] == '0);

endmodule

bind sc_core sc_core_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pc      (imem_addr),
  .op      (f_op),
  .funct   (f_fn),
  .rs_idx  (imem_rdata[25:21]),
  .imm     (f_imm),
  .rs_q    (rf_qa),
  .alu_b   (alu_b),
  .rf_we   (rf_we),
  .mem_we  (dmem_we),
  .br_take (br_take)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sc_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'h00, fn};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  typedef struct packed {
    logic [23:0] tag;
    logic [31:0] pc;
    logic        we;
    logic        chk_addr;
    logic [31:0] addr;
    logic [31:0] wdata;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VEC [NVEC] = '{
    '{"R1 ", 32'h00, 1'b0, 1'b0, 32'h0,    32'h0},         // ori r1 = 8005
    '{"R11", 32'h04, 1'b0, 1'b0, 32'h0,    32'h0},         // ori r2 = 3
    '{"R11", 32'h08, 1'b0, 1'b0, 32'h0,    32'h0},         // addu r3 = r1+r2
    '{"R2 ", 32'h0C, 1'b1, 1'b1, 32'h0,    32'h0000_8008}, // store r3 (R4 zero pad too)
    '{"R11", 32'h10, 1'b0, 1'b0, 32'h0,    32'h0},         // subu r4 = r2-r1
    '{"R3 ", 32'h14, 1'b1, 1'b1, 32'h4,    32'hFFFF_7FFE}, // store r4, wraps
    '{"R9 ", 32'h18, 1'b0, 1'b0, 32'h0,    32'h0},         // ori into r0
    '{"R9 ", 32'h1C, 1'b1, 1'b1, 32'h8,    32'h0},         // store r0 still 0
    '{"R6 ", 32'h20, 1'b1, 1'b1, 32'h8004, 32'h3},         // store r2 at r3-4
    '{"R5 ", 32'h24, 1'b0, 1'b1, 32'h8004, 32'h0},         // load r5 from r3-4
    '{"R11", 32'h28, 1'b0, 1'b0, 32'h0,    32'h0},         // beq r5,r2 taken
    '{"R7 ", 32'h34, 1'b1, 1'b1, 32'hC,    32'h3},         // lands at target, store r5
    '{"R11", 32'h38, 1'b0, 1'b0, 32'h0,    32'h0},         // beq r1,r2 not taken
    '{"R8 ", 32'h3C, 1'b0, 1'b0, 32'h0,    32'h0},         // undefined op 3F
    '{"R10", 32'h40, 1'b0, 1'b0, 32'h0,    32'h0},         // R-format funct 25
    '{"R10", 32'h44, 1'b1, 1'b1, 32'h10,   32'h0000_8008}, // r3 untouched
    '{"R11", 32'h48, 1'b0, 1'b0, 32'h0,    32'h0},         // addu r6 = r4+r1
    '{"R2 ", 32'h4C, 1'b1, 1'b1, 32'h14,   32'h3},         // wrapped sum
    '{"R11", 32'h50, 1'b0, 1'b0, 32'h0,    32'h0},         // beq r0,r0,-1
    '{"R7 ", 32'h50, 1'b0, 1'b0, 32'h0,    32'h0}          // negative offset holds PC
  };

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
    imem[0]  = enc_i(6'h0D, 5'd0, 5'd1, 16'h8005);
    imem[1]  = enc_i(6'h0D, 5'd0, 5'd2, 16'h0003);
    imem[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'h21);
    imem[3]  = enc_i(6'h2B, 5'd0, 5'd3, 16'h0000);
    imem[4]  = enc_r(5'd2, 5'd1, 5'd4, 6'h23);
    imem[5]  = enc_i(6'h2B, 5'd0, 5'd4, 16'h0004);
    imem[6]  = enc_i(6'h0D, 5'd0, 5'd0, 16'h1234);
    imem[7]  = enc_i(6'h2B, 5'd0, 5'd0, 16'h0008);
    imem[8]  = enc_i(6'h2B, 5'd3, 5'd2, 16'hFFFC);
    imem[9]  = enc_i(6'h23, 5'd3, 5'd5, 16'hFFFC);
    imem[10] = enc_i(6'h04, 5'd5, 5'd2, 16'h0002);
    imem[11] = enc_i(6'h2B, 5'd0, 5'd1, 16'h0020);
    imem[12] = enc_i(6'h2B, 5'd0, 5'd1, 16'h0020);
    imem[13] = enc_i(6'h2B, 5'd0, 5'd5, 16'h000C);
    imem[14] = enc_i(6'h04, 5'd1, 5'd2, 16'h0005);
    imem[15] = 32'hFC00_0000;
    imem[16] = enc_r(5'd1, 5'd2, 5'd3, 6'h25);
    imem[17] = enc_i(6'h2B, 5'd0, 5'd3, 16'h0010);
    imem[18] = enc_r(5'd4, 5'd1, 5'd6, 6'h21);
    imem[19] = enc_i(6'h2B, 5'd0, 5'd6, 16'h0014);
    imem[20] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset pc", imem_addr, 32'h0);
    check("R1 reset we", {31'h0, dmem_we}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (i > 0) @(negedge clk);
      check($sformatf("%s vec%0d pc", VEC[i].tag, i), imem_addr, VEC[i].pc);
      check($sformatf("%s vec%0d we", VEC[i].tag, i), {31'h0, dmem_we}, {31'h0, VEC[i].we});
      if (VEC[i].chk_addr)
        check($sformatf("%s vec%0d addr", VEC[i].tag, i), dmem_addr, VEC[i].addr);
      if (VEC[i].we)
        check($sformatf("%s vec%0d wdata", VEC[i].tag, i), dmem_wdata, VEC[i].wdata);
    end

    // R1: asynchronous reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset pc", imem_addr, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R1 held pc", imem_addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 first step", imem_addr, 32'h4);
    @(negedge clk);
    check("R11 second step", imem_addr, 32'h8);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule